// File: doc/BRIEF.md
# Interlaced Field-Locked Vertical Sync Generator

This block produces the output vertical sync and the field timing for an interlaced raster of 525 lines per frame, split into two fields of 262.5 lines. It follows an incoming vertical sync. On each falling edge of that input, it measures where the edge sits within the incoming line, using the horizontal sync as the line reference. An edge near mid-line identifies field B. Any other position identifies field A.

A programmable delay, counted in whole lines from that edge, marks the reference point. At the reference point the output line and half-line counters restart, and the shape, polarity and field-swap settings are taken up. The output sync pulse then follows at a fixed offset from the reference point. There are two pulse shapes. The long shape is 3 lines wide and starts 3 lines after the reference. The short shape is 1.5 lines wide and starts 4 lines after the reference.

Field B events fall half a line later than field A events. After a reference point, the timebase runs freely with a 525-line frame until the next reference. All timing is in half-lines, and the line length is set by a pixel-count parameter.

Top module: `ilace_vsync_gen`

## Requirements
- R1: While reset is held, `ovs_out` is 1, `field_out` is 0 and `half_line_out` is 0.
- R2: For an input sync fall first seen at clock edge E with delay D (0 to 524), the reference point is edge E+1+D·LINE_PIX, and `half_line_out` is 0 right after that edge.
- R3: With `cfg_short_sync`=0, the field-A pulse is active from 6 to 12 half-lines after the reference point, and the output changes only on half-line boundaries.
- R4: With `cfg_short_sync`=1, the field-A pulse is active from 8 to 11 half-lines after the reference point. The field-B pulse is active from 9 to 12 half-lines.
- R5: The input field is B (`field_out`=1) when the sync fall is first seen with between LINE_PIX/4 and 3·LINE_PIX/4−1 clocks elapsed since the last horizontal sync rise was registered. Otherwise the input field is A (`field_out`=0).
- R6: With `cfg_field_swap`=1 at the reference point, the output field phase is the inverse of the detected input field.
- R7: With `cfg_ovs_inv`=0 the pulse is driven low. With `cfg_ovs_inv`=1 it is driven high, and the idle level is inverted as well.
- R8: A delay value above 524 behaves exactly like 524.
- R9: Without new input edges, the second field's pulse comes 525 half-lines after the first, with `field_out` inverted, and the frame repeats every 1050 half-lines.
- R10: Changes to the shape and polarity settings between reference points have no effect on `ovs_out` until the next reference point.
- R11: An input sync fall first seen on the same edge as a pending reference point honours both. The pending reference occurs, and a new delay starts from that edge.
- R12: `half_line_out` is 1 during the second half of each output line, measured from the reference point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| ihs_in | input | 1 | Incoming horizontal sync; a rising edge marks line start |
| ivs_in | input | 1 | Incoming vertical sync; a falling edge is the timing reference |
| cfg_delay | input | DLY_W | Delay in lines from the input sync fall to the reference point |
| cfg_short_sync | input | 1 | 0: 3-line pulse after 3 lines; 1: 1.5-line pulse after 4 lines |
| cfg_field_swap | input | 1 | Inverts the output field phase relative to the input |
| cfg_ovs_inv | input | 1 | Output polarity: 0 active-low, 1 active-high |
| ovs_out | output | 1 | Output vertical sync |
| field_out | output | 1 | Current output field: 0 = A, 1 = B |
| half_line_out | output | 1 | 1 in the second half of the current output line |

## Verification
The delay timer expiring and a fresh input sync fall can land on the same clock edge. When they do, the expiry restarts the output timebase using the previous field decision, while the new fall reloads the timer. The bench provokes this by timing a second fall to arrive exactly when a 2-line delay runs out, after loading a 10-line delay for it. It then expects two complete pulses: one 48 cycles after the shared edge, and one 48 cycles after a reference point 161 cycles later. If the expiry were lost, the first pulse would be missing. If the capture were lost, the second pulse would be missing.

// File: rtl/ivsg_pkg.sv
package ivsg_pkg;

    // Raster geometry in half-line units
    localparam int HL_W      = 11;
    localparam int FIELD_HL  = 525;
    localparam int FRAME_HL  = 1050;
    localparam int MAX_DELAY = 524;

    // Pulse window: start offset and width in half-lines
    localparam int LONG_START  = 6;
    localparam int LONG_WIDTH  = 6;
    localparam int SHORT_START = 8;
    localparam int SHORT_WIDTH = 3;

    typedef enum logic {
        FIELD_A = 1'b0,
        FIELD_B = 1'b1
    } field_e;

    typedef struct packed {
        logic short_sync;
        logic invert;
    } shape_t;

    function automatic logic in_pulse(input logic [HL_W-1:0] frel, input logic short_sync);
        logic [HL_W-1:0] s;
        logic [HL_W-1:0] e;
        s = short_sync ? HL_W'(SHORT_START) : HL_W'(LONG_START);
        e = s + (short_sync ? HL_W'(SHORT_WIDTH) : HL_W'(LONG_WIDTH));
        return (frel >= s) && (frel < e);
    endfunction

endpackage

// File: rtl/ivsg_phase_detect.sv
module ivsg_phase_detect
    import ivsg_pkg::*;
#(
    parameter int LINE_PIX = 16
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   ihs_in,
    input  logic   ivs_in,
    output logic   ivs_fall,
    output field_e fld_cap
);

    localparam int PIX_W = $clog2(LINE_PIX);
    localparam logic [PIX_W-1:0] PIX_LAST = PIX_W'(LINE_PIX - 1);
    localparam logic [PIX_W-1:0] MID_LO   = PIX_W'(LINE_PIX / 4);
    localparam logic [PIX_W-1:0] MID_HI   = PIX_W'((3 * LINE_PIX) / 4);

    logic             ihs_q;
    logic             ivs_q;
    logic [PIX_W-1:0] pix;
    logic             ihs_rise;

    assign ihs_rise = ihs_in & ~ihs_q;
    assign ivs_fall = ivs_q & ~ivs_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            ihs_q   <= 1'b0;
            ivs_q   <= 1'b0;
            pix     <= '0;
            fld_cap <= FIELD_A;
        end else begin
            ihs_q <= ihs_in;
            ivs_q <= ivs_in;
            if (ihs_rise) begin
                pix <= '0;
            end else if (pix != PIX_LAST) begin
                pix <= pix + PIX_W'(1);
            end
            if (ivs_fall) begin
                fld_cap <= ((pix >= MID_LO) && (pix < MID_HI)) ? FIELD_B : FIELD_A;
            end
        end
    end

    // R5: the line position restarts on every horizontal sync rise
    p_line_restart_r5: assert property (@(posedge clk) disable iff (rst)
        ihs_rise |=> (pix == '0));

endmodule

// File: rtl/ivsg_line_delay.sv
module ivsg_line_delay
    import ivsg_pkg::*;
#(
    parameter int LINE_PIX = 16,
    parameter int DLY_W    = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DLY_W-1:0] delay_in,
    output logic             expire
);

    localparam int PIX_W = $clog2(LINE_PIX);
    localparam logic [PIX_W-1:0] PIX_LAST = PIX_W'(LINE_PIX - 1);
    localparam logic [DLY_W-1:0] DLY_MAX  = DLY_W'(MAX_DELAY);

    logic             run;
    logic [PIX_W-1:0] pix;
    logic [DLY_W-1:0] lines;
    logic [DLY_W-1:0] tgt;

    assign expire = run && (lines == tgt) && (pix == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            run   <= 1'b0;
            pix   <= '0;
            lines <= '0;
            tgt   <= '0;
        end else if (start) begin
            run   <= 1'b1;
            pix   <= '0;
            lines <= '0;
            tgt   <= (delay_in > DLY_MAX) ? DLY_MAX : delay_in;
        end else if (expire) begin
            run <= 1'b0;
        end else if (run) begin
            if (pix == PIX_LAST) begin
                pix   <= '0;
                lines <= lines + DLY_W'(1);
            end else begin
                pix <= pix + PIX_W'(1);
            end
        end
    end

    // R8: the armed target never exceeds the legal maximum
    p_target_legal_r8: assert property (@(posedge clk) disable iff (rst)
        run |-> (tgt <= DLY_MAX));

    // R2: one reference point per armed delay unless re-armed at that edge
    p_single_expire_r2: assert property (@(posedge clk) disable iff (rst)
        (expire && !start) |=> !expire);

    // R11: a fall on an expiry edge still arms the timer
    p_rearm_r11: assert property (@(posedge clk) disable iff (rst)
        start |=> run);

endmodule

// File: rtl/ivsg_raster.sv
module ivsg_raster
    import ivsg_pkg::*;
#(
    parameter int LINE_PIX = 16
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   expire,
    input  field_e fld_in,
    input  logic   swap,
    input  shape_t shape_in,
    output logic   ovs,
    output logic   field_out,
    output logic   half_out
);

    localparam int HALF_PIX = LINE_PIX / 2;
    localparam int SUB_W    = $clog2(HALF_PIX);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(HALF_PIX - 1);
    localparam logic [HL_W-1:0]  HL_LAST  = HL_W'(FRAME_HL - 1);
    localparam logic [HL_W-1:0]  HL_FIELD = HL_W'(FIELD_HL);

    logic [SUB_W-1:0] sub;
    logic [HL_W-1:0]  hl;
    field_e           f0;
    shape_t           shape;

    logic [HL_W-1:0]  rel;
    logic [HL_W-1:0]  frel;
    logic             second;
    logic             f0_b;
    logic             active;

    always_ff @(posedge clk) begin
        if (rst) begin
            sub   <= '0;
            hl    <= '0;
            f0    <= FIELD_A;
            shape <= '0;
        end else if (expire) begin
            sub   <= '0;
            hl    <= '0;
            f0    <= swap ? ((fld_in == FIELD_A) ? FIELD_B : FIELD_A) : fld_in;
            shape <= shape_in;
        end else if (sub == SUB_LAST) begin
            sub <= '0;
            hl  <= (hl == HL_LAST) ? '0 : hl + HL_W'(1);
        end else begin
            sub <= sub + SUB_W'(1);
        end
    end

    // Field B starts one half-line after the reference point
    always_comb begin
        f0_b   = (f0 == FIELD_B);
        rel    = (f0_b && (hl == '0)) ? HL_LAST : (hl - HL_W'(f0_b));
        second = (rel >= HL_FIELD);
        frel   = second ? (rel - HL_FIELD) : rel;
        active = in_pulse(frel, shape.short_sync);
    end

    assign ovs       = shape.invert ? active : ~active;
    assign field_out = f0_b ^ second;
    assign half_out  = hl[0];

    // R10: shape and polarity are taken up only at a reference point
    p_shape_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !expire |=> $stable(shape));

    // R3: the output moves only on half-line boundaries or at a reference
    p_ovs_grid_r3: assert property (@(posedge clk) disable iff (rst)
        (!expire && (sub != SUB_LAST)) |=> $stable(ovs));

    // R12: the half-line flag toggles on each half-line step
    p_half_step_r12: assert property (@(posedge clk) disable iff (rst)
        (!expire && (sub == SUB_LAST) && (hl != HL_LAST)) |=> (half_out != $past(half_out)));

endmodule

// File: rtl/ilace_vsync_gen.sv
module ilace_vsync_gen
    import ivsg_pkg::*;
#(
    parameter int LINE_PIX = 16,
    parameter int DLY_W    = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ihs_in,
    input  logic             ivs_in,
    input  logic [DLY_W-1:0] cfg_delay,
    input  logic             cfg_short_sync,
    input  logic             cfg_field_swap,
    input  logic             cfg_ovs_inv,
    output logic             ovs_out,
    output logic             field_out,
    output logic             half_line_out
);

    logic   ivs_fall;
    logic   expire;
    field_e fld_cap;
    shape_t shape_cfg;

    assign shape_cfg.short_sync = cfg_short_sync;
    assign shape_cfg.invert     = cfg_ovs_inv;

    ivsg_phase_detect #(.LINE_PIX(LINE_PIX)) u_detect (
        .clk      (clk),
        .rst      (rst),
        .ihs_in   (ihs_in),
        .ivs_in   (ivs_in),
        .ivs_fall (ivs_fall),
        .fld_cap  (fld_cap)
    );

    ivsg_line_delay #(.LINE_PIX(LINE_PIX), .DLY_W(DLY_W)) u_delay (
        .clk      (clk),
        .rst      (rst),
        .start    (ivs_fall),
        .delay_in (cfg_delay),
        .expire   (expire)
    );

    ivsg_raster #(.LINE_PIX(LINE_PIX)) u_raster (
        .clk       (clk),
        .rst       (rst),
        .expire    (expire),
        .fld_in    (fld_cap),
        .swap      (cfg_field_swap),
        .shape_in  (shape_cfg),
        .ovs       (ovs_out),
        .field_out (field_out),
        .half_out  (half_line_out)
    );

endmodule

// File: tb/ilace_vsync_gen_tb.sv
`timescale 1ns/1ps
module ilace_vsync_gen_tb;

    localparam int LP = 16;
    localparam int HP = LP / 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ihs_in = 1'b0;
    logic        ivs_in = 1'b1;
    logic [10:0] cfg_delay = 11'd3;
    logic        cfg_short = 1'b0;
    logic        cfg_swap = 1'b0;
    logic        cfg_inv = 1'b0;
    logic        ovs;
    logic        fld;
    logic        half;

    int    cyc = 0;
    int    n_chk = 0;
    int    n_err = 0;
    bit    done = 0;
    int    q_cyc[$];
    logic  q_lvl[$];
    string q_tag[$];
    bit    mon_on = 0;
    int    mon_from = 0;
    logic  prev_ovs = 1'b1;
    string cur_tag = "R1";

    ilace_vsync_gen #(.LINE_PIX(LP), .DLY_W(11)) u_dut (
        .clk            (clk),
        .rst            (rst),
        .ihs_in         (ihs_in),
        .ivs_in         (ivs_in),
        .cfg_delay      (cfg_delay),
        .cfg_short_sync (cfg_short),
        .cfg_field_swap (cfg_swap),
        .cfg_ovs_inv    (cfg_inv),
        .ovs_out        (ovs),
        .field_out      (fld),
        .half_line_out  (half)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) ihs_in = (cyc % LP == 0);

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic wait_to(int c);
        while (cyc < c) @(negedge clk);
    endtask

    function automatic int next_e(int from, int res);
        int e = from;
        while (e % LP != res) e++;
        return e;
    endfunction

    task automatic push(int c, logic l, string t);
        q_cyc.push_back(c);
        q_lvl.push_back(l);
        q_tag.push_back(t);
    endtask

    task automatic fall_at(int e0);
        wait_to(e0 - 1);
        ivs_in = 1'b0;
    endtask

    task automatic prepare(int eref, string tag);
        logic idle;
        idle = ~cfg_inv;
        wait_to(eref - 1);
        cur_tag = tag;
        if (ovs !== idle) push(eref, idle, tag);
        mon_from = eref;
        mon_on = 1;
    endtask

    task automatic finish_test(int last);
        wait_to(last + 4);
        while (q_cyc.size() > 0) begin
            chk(0, q_tag[0], "missing OVS edge at cycle", -1, q_cyc[0]);
            void'(q_cyc.pop_front());
            void'(q_lvl.pop_front());
            void'(q_tag.pop_front());
        end
        mon_on = 0;
    endtask

    // Monitor: every OVS edge after the reference point is matched against the scoreboard
    always @(negedge clk) begin
        int    ec;
        logic  el;
        string et;
        if (mon_on && cyc >= mon_from && ovs !== prev_ovs) begin
            if (q_cyc.size() == 0) begin
                chk(0, cur_tag, "unexpected OVS edge at cycle", cyc, -1);
            end else begin
                ec = q_cyc.pop_front();
                el = q_lvl.pop_front();
                et = q_tag.pop_front();
                chk(cyc == ec, et, "OVS edge cycle", cyc, ec);
                chk(ovs === el, et, "OVS edge level", int'(ovs), int'(el));
            end
        end
        prev_ovs = ovs;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int e0;
        int eref;
        int ex;

        // R1: reset state
        wait_to(2);
        chk(ovs === 1'b1, "R1", "ovs during reset", int'(ovs), 1);
        chk(fld === 1'b0, "R1", "field during reset", int'(fld), 0);
        chk(half === 1'b0, "R1", "half-line during reset", int'(half), 0);
        wait_to(3);
        rst = 1'b0;

        // R2/R3/R9/R10/R12: long pulse, field A, delay 3, then free-run
        cfg_delay = 11'd3;
        e0 = next_e(cyc + 20, 2);
        fall_at(e0);
        eref = e0 + 1 + 3 * LP;
        prepare(eref, "R3");
        push(eref + 6 * HP, 1'b0, "R2");
        push(eref + 12 * HP, 1'b1, "R3");
        push(eref + 531 * HP, 1'b0, "R9");
        push(eref + 537 * HP, 1'b1, "R9");
        push(eref + 1056 * HP, 1'b0, "R9");
        push(eref + 1062 * HP, 1'b1, "R9");
        wait_to(eref);
        chk(half === 1'b0, "R12", "half-line at reference", int'(half), 0);
        wait_to(eref + 2);
        ivs_in = 1'b1;
        wait_to(eref + HP);
        chk(half === 1'b1, "R12", "half-line in second half", int'(half), 1);
        wait_to(eref + 10);
        cfg_short = 1'b1;
        cfg_inv = 1'b1;
        wait_to(eref + 3 * HP);
        chk(fld === 1'b0, "R5", "field A detected", int'(fld), 0);
        wait_to(eref + 50);
        chk(ovs === 1'b0, "R10", "ovs after config change", int'(ovs), 0);
        wait_to(eref + 600 * HP);
        chk(fld === 1'b1, "R9", "second field flag", int'(fld), 1);
        finish_test(eref + 1062 * HP);
        cfg_inv = 1'b0;

        // R4/R5: short pulse, field B, delay 0
        cfg_delay = 11'd0;
        e0 = next_e(cyc + 20, 10);
        fall_at(e0);
        eref = e0 + 1;
        prepare(eref, "R4");
        push(eref + 9 * HP, 1'b0, "R4");
        push(eref + 12 * HP, 1'b1, "R4");
        wait_to(eref + 2);
        ivs_in = 1'b1;
        wait_to(eref + 3 * HP);
        chk(fld === 1'b1, "R5", "field B detected", int'(fld), 1);
        finish_test(eref + 12 * HP);

        // R6: swap turns field A input into field B timing
        cfg_short = 1'b0;
        cfg_swap = 1'b1;
        cfg_delay = 11'd1;
        e0 = next_e(cyc + 20, 2);
        fall_at(e0);
        eref = e0 + 1 + LP;
        prepare(eref, "R6");
        push(eref + 7 * HP, 1'b0, "R6");
        push(eref + 13 * HP, 1'b1, "R6");
        wait_to(eref + 2);
        ivs_in = 1'b1;
        wait_to(eref + 3 * HP);
        chk(fld === 1'b1, "R6", "swapped field flag", int'(fld), 1);
        finish_test(eref + 13 * HP);
        cfg_swap = 1'b0;

        // R7: inverted polarity
        cfg_inv = 1'b1;
        cfg_delay = 11'd2;
        e0 = next_e(cyc + 20, 2);
        fall_at(e0);
        eref = e0 + 1 + 2 * LP;
        prepare(eref, "R7");
        push(eref + 6 * HP, 1'b1, "R7");
        push(eref + 12 * HP, 1'b0, "R7");
        wait_to(eref + 2);
        ivs_in = 1'b1;
        chk(ovs === 1'b0, "R7", "inverted idle level", int'(ovs), 0);
        finish_test(eref + 12 * HP);

        // R8: out-of-range delay acts as 524
        cfg_inv = 1'b0;
        cfg_delay = 11'd2047;
        e0 = next_e(cyc + 20, 2);
        fall_at(e0);
        eref = e0 + 1 + 524 * LP;
        prepare(eref, "R8");
        push(eref + 6 * HP, 1'b0, "R8");
        push(eref + 12 * HP, 1'b1, "R8");
        wait_to(eref + 2);
        ivs_in = 1'b1;
        finish_test(eref + 12 * HP);

        // R11: new fall on the very edge the pending delay expires
        cfg_delay = 11'd2;
        e0 = next_e(cyc + 20, 2);
        fall_at(e0);
        wait_to(e0 + 3);
        ivs_in = 1'b1;
        cfg_delay = 11'd10;
        ex = e0 + 1 + 2 * LP;
        fall_at(ex);
        prepare(ex, "R11");
        push(ex + 6 * HP, 1'b0, "R11");
        push(ex + 12 * HP, 1'b1, "R11");
        push(ex + 1 + 10 * LP + 6 * HP, 1'b0, "R11");
        push(ex + 1 + 10 * LP + 12 * HP, 1'b1, "R11");
        wait_to(ex + 2);
        ivs_in = 1'b1;
        finish_test(ex + 1 + 10 * LP + 12 * HP);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule